// File: doc/BRIEF.md
# Effective Address Generation Unit

This block turns an addressing-mode code and the operand bytes of one instruction into the 24-bit address the instruction will use. It is built for a 16-bit extended 6502-family processor. It also takes the direct page base, the data and program bank registers, both index registers, the stack pointer and the index-width flag. A start pulse in the idle state captures all of these inputs. After a mode-dependent number of cycles, the unit returns the address together with a one-cycle done strobe.

Some modes do not name the target directly. They name a two- or three-byte pointer held in memory. For these modes the unit uses a byte-wide read port and fetches the pointer bytes itself, low byte first, one byte per cycle. Only then does it form the final address. The bank of the final address is chosen by the mode: the data bank, the program bank, bank zero, the top operand byte, or the third pointer byte. Instruction decode, data operand fetch and arithmetic are handled elsewhere.

Top module: `ea_gen`

## Requirements
- R1: After reset, and with no start pulse, `done_o` and `mem_req_o` are both 0.
- R2: Mode 0 gives {data bank, operand[15:0]}. Mode 1 (control transfer) gives {program bank, operand[15:0]}. Operand byte 0 is the low address byte and byte 1 is the high byte. Done is asserted in the cycle after the start pulse is sampled.
- R3: Mode 2 adds X to, and mode 3 adds Y to, the 24-bit value {data bank, operand[15:0]}. A carry out of bit 15 increments the bank.
- R4: Mode 4 uses all three operand bytes as the address, with byte 2 as the bank. Mode 5 adds X to that 24-bit value, wrapping modulo 2^24.
- R5: Mode 6 gives {0x00, D + operand byte 0}. Modes 7 and 8 also add X or Y. Mode 15 gives {0x00, S + operand byte 0}. All of these sums wrap within 16 bits, so the bank stays 0x00.
- R6: When `idx8_i` is 1 at start, bits 15:8 of X and Y count as zero in every sum that uses them.
- R7: A pointer of N bytes is read over N consecutive cycles with `mem_req_o` high. The first address is the pointer location. Each later address adds 1 to bits 15:0 (wrapping) with the bank unchanged. `mem_rdata_i` is taken in the same cycle as the request. Done follows in cycle N+1 after start. Done and a request are never asserted in the same cycle.
- R8: The pointer location for modes 9 to 12 is {0x00, D + operand byte 0}.
  - Mode 9 reads a 2-byte pointer P and gives {data bank, P}.
  - Mode 10 gives {data bank, P} + Y over 24 bits.
  - Mode 11 reads a 3-byte pointer and uses it as the address.
  - Mode 12 adds Y to that 3-byte pointer.
- R9: Mode 13 reads a 2-byte pointer from {0x00, operand[15:0]}. Mode 14 reads it from {program bank, operand[15:0] + X}, where the sum wraps within 16 bits. Both give {program bank, pointer}.
- R10: Done is a one-cycle pulse. All inputs are captured at the accepted start, so later changes to them do not affect the result. A start pulse while the unit is busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, accepted only when idle |
| mode_i | input | 4 | Addressing-mode code |
| opnd_i | input | 24 | Operand bytes; byte 0 in bits 7:0 |
| dp_i | input | 16 | Direct page base D |
| dbank_i | input | 8 | Data bank register |
| pbank_i | input | 8 | Program bank register |
| x_i | input | 16 | X index register |
| y_i | input | 16 | Y index register |
| sp_i | input | 16 | Stack pointer S |
| idx8_i | input | 1 | 1 selects 8-bit index registers |
| mem_req_o | output | 1 | Pointer byte read request |
| mem_addr_o | output | 24 | Pointer byte address |
| mem_rdata_i | input | 8 | Read data, valid in the cycle of the request |
| done_o | output | 1 | One-cycle completion strobe |
| addr_o | output | 24 | Effective address, valid while done_o is 1 |

## Verification
A start pulse sampled at one clock edge is counted as cycle 0. For the direct modes, done is due in cycle 1. For a pointer mode of N bytes, requests are due in cycles 1 through N and done in cycle N+1. The bench drives the start pulse on a falling edge and then samples the outputs at each following falling edge. At every one of those points it compares request, request address and done against the expected schedule, and it compares the address in the done cycle. Right after the capture edge the bench changes all inputs. In one run it also holds start high while the unit is busy, and the expected address must still match the values captured at the original start.

// File: rtl/ea_pkg.sv
package ea_pkg;
  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned WORD_W  = 2 * BYTE_W;
  localparam int unsigned ADDR_W  = 3 * BYTE_W;
  localparam int unsigned MODE_W  = 4;
  localparam int unsigned CNT_W   = 2;
  localparam int unsigned N_IDX   = 2;

  typedef enum logic [MODE_W-1:0] {
    EA_ABS_DATA   = 4'd0,
    EA_ABS_CTRL   = 4'd1,
    EA_ABS_X      = 4'd2,
    EA_ABS_Y      = 4'd3,
    EA_LONG       = 4'd4,
    EA_LONG_X     = 4'd5,
    EA_DP         = 4'd6,
    EA_DP_X       = 4'd7,
    EA_DP_Y       = 4'd8,
    EA_DP_IND     = 4'd9,
    EA_DP_IND_Y   = 4'd10,
    EA_DP_INDL    = 4'd11,
    EA_DP_INDL_Y  = 4'd12,
    EA_JMP_IND    = 4'd13,
    EA_JMP_IND_X  = 4'd14,
    EA_STK_REL    = 4'd15
  } ea_mode_e;

  typedef enum logic [1:0] {PLOC_DP, PLOC_ABS0, PLOC_ABSX_PB} ploc_e;

  typedef enum logic [2:0] {
    BASE_DB_OP, BASE_PB_OP, BASE_LONG, BASE_DP,
    BASE_SP, BASE_DB_PTR, BASE_PB_PTR, BASE_PTR24
  } base_e;

  typedef enum logic [1:0] {IDX_NONE, IDX_X, IDX_Y} idx_e;

  typedef struct packed {
    logic [CNT_W-1:0] ptr_len;
    ploc_e            ploc;
    base_e            base;
    idx_e             idx;
    logic             in_bank;
  } ea_ctl_t;
endpackage

// File: rtl/ea_mode_dec.sv
module ea_mode_dec
  import ea_pkg::*;
(
  input  logic [MODE_W-1:0] mode_i,
  output ea_ctl_t           ctl_o
);
  always_comb begin
    ctl_o = '{ptr_len: 2'd0, ploc: PLOC_DP, base: BASE_DB_OP, idx: IDX_NONE, in_bank: 1'b0};
    case (ea_mode_e'(mode_i))
      EA_ABS_DATA:  ctl_o.base = BASE_DB_OP;
      EA_ABS_CTRL:  ctl_o.base = BASE_PB_OP;
      EA_ABS_X:     begin ctl_o.base = BASE_DB_OP; ctl_o.idx = IDX_X; end
      EA_ABS_Y:     begin ctl_o.base = BASE_DB_OP; ctl_o.idx = IDX_Y; end
      EA_LONG:      ctl_o.base = BASE_LONG;
      EA_LONG_X:    begin ctl_o.base = BASE_LONG; ctl_o.idx = IDX_X; end
      EA_DP:        ctl_o.base = BASE_DP;
      EA_DP_X:      begin ctl_o.base = BASE_DP; ctl_o.idx = IDX_X; ctl_o.in_bank = 1'b1; end
      EA_DP_Y:      begin ctl_o.base = BASE_DP; ctl_o.idx = IDX_Y; ctl_o.in_bank = 1'b1; end
      EA_DP_IND:    begin ctl_o.ptr_len = 2'd2; ctl_o.base = BASE_DB_PTR; end
      EA_DP_IND_Y:  begin ctl_o.ptr_len = 2'd2; ctl_o.base = BASE_DB_PTR; ctl_o.idx = IDX_Y; end
      EA_DP_INDL:   begin ctl_o.ptr_len = 2'd3; ctl_o.base = BASE_PTR24; end
      EA_DP_INDL_Y: begin ctl_o.ptr_len = 2'd3; ctl_o.base = BASE_PTR24; ctl_o.idx = IDX_Y; end
      EA_JMP_IND:   begin ctl_o.ptr_len = 2'd2; ctl_o.ploc = PLOC_ABS0; ctl_o.base = BASE_PB_PTR; end
      EA_JMP_IND_X: begin ctl_o.ptr_len = 2'd2; ctl_o.ploc = PLOC_ABSX_PB; ctl_o.base = BASE_PB_PTR; end
      EA_STK_REL:   ctl_o.base = BASE_SP;
      default:      ;
    endcase
  end
endmodule

// File: rtl/ea_idx_mask.sv
module ea_idx_mask
  import ea_pkg::*;
(
  input  logic [WORD_W-1:0] val_i,
  input  logic              narrow_i,
  output logic [WORD_W-1:0] val_o
);
  assign val_o = narrow_i ? {{(WORD_W-BYTE_W){1'b0}}, val_i[BYTE_W-1:0]} : val_i;
endmodule

// File: rtl/ea_addr_calc.sv
module ea_addr_calc
  import ea_pkg::*;
(
  input  ea_ctl_t           ctl_i,
  input  logic [ADDR_W-1:0] opnd_i,
  input  logic [WORD_W-1:0] dp_i,
  input  logic [BYTE_W-1:0] dbank_i,
  input  logic [BYTE_W-1:0] pbank_i,
  input  logic [WORD_W-1:0] x_i,
  input  logic [WORD_W-1:0] y_i,
  input  logic [WORD_W-1:0] sp_i,
  input  logic [ADDR_W-1:0] ptr_i,
  output logic [ADDR_W-1:0] ploc_o,
  output logic [ADDR_W-1:0] ea_o
);
  localparam logic [BYTE_W-1:0] BANK0 = '0;

  logic [WORD_W-1:0] op16, op8, dp_sum, sp_sum, idx_val;
  logic [ADDR_W-1:0] base;

  assign op16   = opnd_i[WORD_W-1:0];
  assign op8    = {{(WORD_W-BYTE_W){1'b0}}, opnd_i[BYTE_W-1:0]};
  assign dp_sum = dp_i + op8;
  assign sp_sum = sp_i + op8;

  always_comb begin
    case (ctl_i.ploc)
      PLOC_ABS0:    ploc_o = {BANK0, op16};
      PLOC_ABSX_PB: ploc_o = {pbank_i, op16 + x_i};
      default:      ploc_o = {BANK0, dp_sum};
    endcase
  end

  always_comb begin
    case (ctl_i.base)
      BASE_DB_OP:  base = {dbank_i, op16};
      BASE_PB_OP:  base = {pbank_i, op16};
      BASE_LONG:   base = opnd_i;
      BASE_DP:     base = {BANK0, dp_sum};
      BASE_SP:     base = {BANK0, sp_sum};
      BASE_DB_PTR: base = {dbank_i, ptr_i[WORD_W-1:0]};
      BASE_PB_PTR: base = {pbank_i, ptr_i[WORD_W-1:0]};
      default:     base = ptr_i;
    endcase
  end

  always_comb begin
    case (ctl_i.idx)
      IDX_X:   idx_val = x_i;
      IDX_Y:   idx_val = y_i;
      default: idx_val = '0;
    endcase
  end

  always_comb begin
    if (ctl_i.in_bank)
      ea_o = {base[ADDR_W-1:WORD_W], base[WORD_W-1:0] + idx_val};
    else
      ea_o = base + {{(ADDR_W-WORD_W){1'b0}}, idx_val};
  end
endmodule

// File: rtl/ea_ptr_seq.sv
module ea_ptr_seq
  import ea_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [CNT_W-1:0]  len_i,
  input  logic [ADDR_W-1:0] ploc_i,
  input  logic [BYTE_W-1:0] rdata_i,
  output logic              req_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [ADDR_W-1:0] ptr_o,
  output logic              done_o,
  output logic              idle_o
);
  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_DONE} state_e;

  state_e            state_q;
  logic [CNT_W-1:0]  cnt_q, len_q;
  logic [ADDR_W-1:0] ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      cnt_q   <= '0;
      len_q   <= '0;
      ptr_q   <= '0;
    end else begin
      case (state_q)
        S_IDLE: if (start_i) begin
          ptr_q   <= '0;
          cnt_q   <= '0;
          len_q   <= len_i;
          state_q <= (len_i == '0) ? S_DONE : S_FETCH;
        end
        S_FETCH: begin
          ptr_q[cnt_q*BYTE_W +: BYTE_W] <= rdata_i;
          if (cnt_q == len_q - 1'b1) state_q <= S_DONE;
          else                       cnt_q   <= cnt_q + 1'b1;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign req_o  = (state_q == S_FETCH);
  assign done_o = (state_q == S_DONE);
  assign idle_o = (state_q == S_IDLE);
  assign ptr_o  = ptr_q;
  // pointer bytes stay in the bank of the first byte
  assign addr_o = {ploc_i[ADDR_W-1:WORD_W], ploc_i[WORD_W-1:0] + WORD_W'(cnt_q)};
endmodule

// File: rtl/ea_gen.sv
module ea_gen
  import ea_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic [ADDR_W-1:0] opnd_i,
  input  logic [WORD_W-1:0] dp_i,
  input  logic [BYTE_W-1:0] dbank_i,
  input  logic [BYTE_W-1:0] pbank_i,
  input  logic [WORD_W-1:0] x_i,
  input  logic [WORD_W-1:0] y_i,
  input  logic [WORD_W-1:0] sp_i,
  input  logic              idx8_i,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic [BYTE_W-1:0] mem_rdata_i,
  output logic              done_o,
  output logic [ADDR_W-1:0] addr_o
);
  ea_ctl_t           ctl_in, ctl_q;
  logic [ADDR_W-1:0] opnd_q, ptr, ploc;
  logic [WORD_W-1:0] dp_q, sp_q;
  logic [BYTE_W-1:0] db_q, pb_q;
  logic              i8_q, idle, accept;
  logic [WORD_W-1:0] idx_raw [N_IDX];
  logic [WORD_W-1:0] idx_msk [N_IDX];

  assign accept = start_i & idle;

  ea_mode_dec i_dec (.mode_i(mode_i), .ctl_o(ctl_in));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q  <= '0;
      opnd_q <= '0;
      dp_q   <= '0;
      sp_q   <= '0;
      db_q   <= '0;
      pb_q   <= '0;
      i8_q   <= 1'b0;
      for (int i = 0; i < N_IDX; i++) idx_raw[i] <= '0;
    end else if (accept) begin
      ctl_q      <= ctl_in;
      opnd_q     <= opnd_i;
      dp_q       <= dp_i;
      sp_q       <= sp_i;
      db_q       <= dbank_i;
      pb_q       <= pbank_i;
      i8_q       <= idx8_i;
      idx_raw[0] <= x_i;
      idx_raw[1] <= y_i;
    end
  end

  for (genvar gi = 0; gi < N_IDX; gi++) begin : g_idx
    ea_idx_mask i_mask (.val_i(idx_raw[gi]), .narrow_i(i8_q), .val_o(idx_msk[gi]));
  end

  ea_addr_calc i_calc (
    .ctl_i(ctl_q), .opnd_i(opnd_q), .dp_i(dp_q), .dbank_i(db_q), .pbank_i(pb_q),
    .x_i(idx_msk[0]), .y_i(idx_msk[1]), .sp_i(sp_q), .ptr_i(ptr),
    .ploc_o(ploc), .ea_o(addr_o)
  );

  ea_ptr_seq i_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(accept), .len_i(ctl_in.ptr_len),
    .ploc_i(ploc), .rdata_i(mem_rdata_i), .req_o(mem_req_o), .addr_o(mem_addr_o),
    .ptr_o(ptr), .done_o(done_o), .idle_o(idle)
  );
endmodule

// File: rtl/ea_gen_chk.sv
module ea_gen_chk
  import ea_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic [MODE_W-1:0] mode_i,
  input logic              mem_req_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              done_o
);
  logic idle_seen, ind_mode;
  assign idle_seen = !mem_req_o && !done_o;
  assign ind_mode  = (mode_i >= 4'd9) && (mode_i <= 4'd14);

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R10
  AST_REQ_DONE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_req_o && done_o)); // R7
  AST_REQ_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && $past(mem_req_o)) |->
      (mem_addr_o[WORD_W-1:0] == $past(mem_addr_o[WORD_W-1:0]) + 16'd1) &&
      (mem_addr_o[ADDR_W-1:WORD_W] == $past(mem_addr_o[ADDR_W-1:WORD_W]))); // R7
  AST_DIRECT_LAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && idle_seen && !ind_mode) |=> (done_o && !mem_req_o)); // R2
  AST_IND_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && idle_seen && ind_mode) |=> mem_req_o); // R7
  AST_FETCH_ENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |=> (mem_req_o || done_o)); // R10
endmodule

bind ea_gen ea_gen_chk i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .mode_i(mode_i),
  .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o), .done_o(done_o)
);

// File: tb/test_ea_gen.sv
module test_ea_gen;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        start = 1'b0, idx8 = 1'b0;
  logic [3:0]  mode = '0;
  logic [23:0] opnd = '0;
  logic [15:0] dp = '0, x = '0, y = '0, sp = '0;
  logic [7:0]  db = '0, pb = '0;
  logic        mem_req, done;
  logic [23:0] mem_addr, addr;
  logic [7:0]  mem_rdata;
  int checks = 0, errors = 0, cyc = 0;

  always #10 clk = ~clk;

  ea_gen i_ea_gen (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .mode_i(mode), .opnd_i(opnd),
    .dp_i(dp), .dbank_i(db), .pbank_i(pb), .x_i(x), .y_i(y), .sp_i(sp), .idx8_i(idx8),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_rdata_i(mem_rdata),
    .done_o(done), .addr_o(addr)
  );

  function automatic logic [7:0] mem_byte(input logic [23:0] a);
    return a[7:0] ^ {a[12:8], a[15:13]} ^ (a[23:16] + 8'h3A) ^ 8'h5C;
  endfunction

  always_comb mem_rdata = mem_byte(mem_addr);

  function automatic logic [23:0] rd_ptr(input logic [23:0] loc, input int n);
    logic [23:0] r = '0;
    for (int i = 0; i < n; i++)
      r[8*i +: 8] = mem_byte({loc[23:16], loc[15:0] + 16'(i)});
    return r;
  endfunction

  function automatic int plen(input logic [3:0] m);
    if (m == 4'd11 || m == 4'd12) return 3;
    if (m >= 4'd9 && m <= 4'd14) return 2;
    return 0;
  endfunction

  function automatic string req_tag(input logic [3:0] m);
    case (m)
      4'd0, 4'd1: return "R2";
      4'd2, 4'd3: return "R3";
      4'd4, 4'd5: return "R4";
      4'd13, 4'd14: return "R9";
      4'd9, 4'd10, 4'd11, 4'd12: return "R8";
      default: return "R5";
    endcase
  endfunction

  function automatic logic [23:0] exp_loc(input logic [3:0] m, input logic [23:0] op,
      input logic [15:0] d, input logic [7:0] p, input logic [15:0] xm);
    if (m == 4'd13) return {8'h00, op[15:0]};
    if (m == 4'd14) return {p, op[15:0] + xm};
    return {8'h00, d + {8'h00, op[7:0]}};
  endfunction

  function automatic logic [23:0] exp_ea(input logic [3:0] m, input logic [23:0] op,
      input logic [15:0] d, input logic [7:0] dbk, input logic [7:0] pbk,
      input logic [15:0] xm, input logic [15:0] ym, input logic [15:0] s);
    logic [23:0] loc = exp_loc(m, op, d, pbk, xm);
    logic [23:0] p = rd_ptr(loc, plen(m));
    logic [15:0] dpa = d + {8'h00, op[7:0]};
    case (m)
      4'd0:  return {dbk, op[15:0]};
      4'd1:  return {pbk, op[15:0]};
      4'd2:  return {dbk, op[15:0]} + {8'h00, xm};
      4'd3:  return {dbk, op[15:0]} + {8'h00, ym};
      4'd4:  return op;
      4'd5:  return op + {8'h00, xm};
      4'd6:  return {8'h00, dpa};
      4'd7:  return {8'h00, dpa + xm};
      4'd8:  return {8'h00, dpa + ym};
      4'd9:  return {dbk, p[15:0]};
      4'd10: return {dbk, p[15:0]} + {8'h00, ym};
      4'd11: return p;
      4'd12: return p + {8'h00, ym};
      4'd13, 4'd14: return {pbk, p[15:0]};
      default: return {8'h00, s + {8'h00, op[7:0]}};
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic run_op(input logic [3:0] m, input logic [23:0] op, input logic [15:0] d,
      input logic [7:0] dbk, input logic [7:0] pbk, input logic [15:0] xv,
      input logic [15:0] yv, input logic [15:0] s, input bit i8, input bit hold,
      input string tag);
    logic [15:0] xm = i8 ? {8'h00, xv[7:0]} : xv;
    logic [15:0] ym = i8 ? {8'h00, yv[7:0]} : yv;
    int n = plen(m);
    logic [23:0] loc = exp_loc(m, op, d, pbk, xm);
    logic [23:0] ea = exp_ea(m, op, d, dbk, pbk, xm, ym, s);
    @(negedge clk);
    mode = m; opnd = op; dp = d; db = dbk; pb = pbk; x = xv; y = yv; sp = s; idx8 = i8;
    start = 1'b1;
    for (int k = 1; k <= n + 1; k++) begin
      @(negedge clk);
      if (k == 1) begin // R10: inputs changed after capture
        mode = 4'($urandom); opnd = 24'($urandom); dp = 16'($urandom);
        x = 16'($urandom); y = 16'($urandom); sp = 16'($urandom);
        db = 8'($urandom); pb = 8'($urandom); idx8 = 1'($urandom);
        start = hold;
      end
      chk(mem_req == (k <= n), "R7", "mem_req_o", 32'(mem_req), 32'(k <= n));
      if (k <= n) begin
        logic [23:0] ea_b = {loc[23:16], loc[15:0] + 16'(k - 1)};
        chk(mem_addr == ea_b, "R7", "mem_addr_o", 32'(mem_addr), 32'(ea_b));
      end
      chk(done == (k == n + 1), "R10", "done_o timing", 32'(done), 32'(k == n + 1));
      if (k == n + 1) begin
        chk(addr == ea, tag, "addr_o", 32'(addr), 32'(ea));
        start = 1'b0;
      end
    end
    @(negedge clk);
    chk(!done && !mem_req, "R10", "done pulse end", 32'({done, mem_req}), 32'h0);
  endtask

  initial begin : watchdog
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        errors++;
        $display("FAIL R10 watchdog: actual %0d expected %0d", cyc, 150000);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin : stim
    int unsigned seed;
    seed = $urandom(32'd20240611);
    repeat (3) @(negedge clk);
    chk(!done && !mem_req, "R1", "reset outputs", 32'({done, mem_req}), 32'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!done && !mem_req, "R1", "idle outputs", 32'({done, mem_req}), 32'h0);

    // directed corners
    run_op(4'd2, 24'h00FFF0, 16'h0, 8'h12, 8'h00, 16'h0020, 16'h0, 16'h0, 1'b0, 1'b0, "R3");
    run_op(4'd7, 24'h000020, 16'hFFF0, 8'h44, 8'h55, 16'h0005, 16'h0, 16'h0, 1'b0, 1'b0, "R5");
    run_op(4'd3, 24'h001000, 16'h0, 8'h01, 8'h00, 16'h0, 16'hABCD, 16'h0, 1'b1, 1'b0, "R6");
    run_op(4'd5, 24'hFFFFF0, 16'h0, 8'h00, 8'h00, 16'h12F0, 16'h0, 16'h0, 1'b1, 1'b0, "R6");
    run_op(4'd11, 24'h000001, 16'hFFFE, 8'h00, 8'h00, 16'h0, 16'h0, 16'h0, 1'b0, 1'b0, "R8");
    run_op(4'd5, 24'hFFFFFF, 16'h0, 8'h00, 8'h00, 16'h0001, 16'h0, 16'h0, 1'b0, 1'b0, "R4");
    run_op(4'd10, 24'h000033, 16'h2100, 8'h7F, 8'h00, 16'h0, 16'hFFFF, 16'h0, 1'b0, 1'b1, "R10");
    run_op(4'd14, 24'h001234, 16'h0, 8'h00, 8'h7E, 16'h0010, 16'h0, 16'h0, 1'b0, 1'b0, "R9");
    run_op(4'd13, 24'h00FFFF, 16'h0, 8'h00, 8'hC0, 16'h0, 16'h0, 16'h0, 1'b0, 1'b0, "R9");
    run_op(4'd15, 24'h000003, 16'h0, 8'h00, 8'h00, 16'h0, 16'h0, 16'h01FF, 1'b0, 1'b0, "R5");
    run_op(4'd1, 24'h00BEEF, 16'h0, 8'h11, 8'h22, 16'h0, 16'h0, 16'h0, 1'b0, 1'b0, "R2");

    // constrained random over all modes
    for (int t = 0; t < 400; t++) begin
      logic [3:0] m = 4'($urandom);
      run_op(m, 24'($urandom), 16'($urandom), 8'($urandom), 8'($urandom),
             16'($urandom), 16'($urandom), 16'($urandom), 1'($urandom),
             ($urandom % 8) == 0, req_tag(m));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule